// File: doc/BRIEF.md
# Page Table Walker with Referenced/Dirty Write-Back

This block translates a virtual address by reading page table entries from memory, one level at a time. It starts at a root table base and goes down through three index levels until it finds a leaf entry, hits an invalid entry, or runs out of levels. A requester starts a walk with a pulse on `start`. The requester also supplies the virtual address, the table root and a six-bit mask of the permissions the access wants. The walker holds `busy` while it works and pulses `done` for one cycle when `pte_out` carries the result.

When a leaf grants at least one of the wanted permissions, the walker sets the entry's referenced bit. If a write permission is wanted, it also sets the dirty bit. It stores the updated entry back to memory with one write, and only when that write changes the entry. A leaf found above the last level is a superpage. For such a leaf, the unused low virtual page number bits are merged into the returned entry, so a TLB can be filled from it directly. Any failure returns an all-zero entry. Deciding whether the access faults is left to the requester.

Top module: `pgwalk`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low.
- R2: A `start` seen while idle raises `busy` on the next cycle. `done` is a one-cycle pulse with `busy` low, and `pte_out` is valid during it. A `start` pulse while busy is ignored.
- R3: Bits 63 down to 41 of the address must all be equal. If they are not, the result is zero, no memory request is made, and `done` follows in the cycle after `start`.
- R4: Level 2 is read first. For level k the read address is base + 8 × va[12+10k +: 10]. The base for the next level is the non-leaf entry with bits 11:0 cleared.
- R5: An entry with bit 0 (valid) clear ends the walk with a zero result.
- R6: A valid entry is a leaf when any of bits 8:3 is set. Bit 3 is user read, bit 4 user write, bit 5 user execute, bit 6 supervisor read, bit 7 supervisor write and bit 8 supervisor execute. A non-leaf entry at level 0 gives a zero result.
- R7: At a leaf, bit 1 (referenced) is set only when (entry bits 8:3) AND `want` is non-zero. `want` bit i lines up with entry bit 3+i.
- R8: When the referenced bit is set, bit 2 (dirty) is also set if `want` bit 1 or bit 4 is set.
- R9: An updated leaf is written back once to its own address before `done`. No write happens when the entry would not change.
- R10: For a leaf at level k, the result is the updated entry ORed with (va[12 +: 10k]) shifted left by 12.
- R11: A memory request is a one-cycle `mem_req` pulse. The next request waits for `mem_rsp_valid` on the previous one. A write is acknowledged by `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken when idle) |
| va | input | 64 | Virtual address to translate |
| want | input | 6 | Wanted permission mask, bit i matching entry bit 3+i |
| root_base | input | 64 | Physical base of the top-level table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse, result valid |
| pte_out | output | 64 | Leaf entry for a TLB fill, or zero |
| mem_req | output | 1 | One-cycle memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the entry |
| mem_wdata | output | 64 | Entry written back |
| mem_rsp_valid | input | 1 | Read data valid or write acknowledged |
| mem_rdata | input | 64 | Entry read from memory |

## Verification
The sweep places a leaf at each of the three levels. It crosses every single wanted permission bit with leaf permission sets that partly match, fully match, or miss. This separates the referenced-only, referenced-plus-dirty and untouched outcomes, and it shows the superpage merge width changing with the level. Memory latency is varied so that response timing cannot hide a handshake error. Directed walks cover the remaining cases:
- an address with mixed high bits;
- a negative canonical address;
- an invalid entry at each level;
- a non-leaf entry at the bottom level;
- a leaf that is already marked referenced and dirty;
- a leaf marked referenced that still needs the dirty bit;
- a `start` pulse while busy.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int XLEN     = 64;
  localparam int PTE_V    = 0;
  localparam int PTE_REF  = 1;
  localparam int PTE_DRT  = 2;
  localparam int PERM_LSB = 3;
  localparam int PERM_W   = 6;
  // wanted-permission bits that denote a write (user and supervisor)
  localparam logic [PERM_W-1:0] WRITE_MASK = 6'b010010;

  typedef enum logic [2:0] {
    W_IDLE, W_RREQ, W_RWAIT, W_WREQ, W_WWAIT, W_DONE
  } wstate_e;
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr import pgw_pkg::*; #(
  parameter int LEVELS    = 3,
  parameter int IDX_BITS  = 10,
  parameter int PG_SHIFT  = 12,
  parameter int PTE_BYTES = 8,
  localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int OFS      = $clog2(PTE_BYTES)
) (
  input  logic [XLEN-1:0]  va,
  input  logic [XLEN-1:0]  base,
  input  logic [LVL_W-1:0] lvl,
  output logic [XLEN-1:0]  addr
);
  logic [IDX_BITS-1:0] idx;

  // pick the index field belonging to the current level
  always_comb begin
    idx = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl == LVL_W'(l)) idx = va[PG_SHIFT + l*IDX_BITS +: IDX_BITS];
    end
  end

  assign addr = base + (XLEN'(idx) << OFS);
endmodule

// File: rtl/pgw_leaf.sv
module pgw_leaf import pgw_pkg::*; #(
  parameter int LEVELS   = 3,
  parameter int IDX_BITS = 10,
  parameter int PG_SHIFT = 12,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [XLEN-1:0]   pte,
  input  logic [PERM_W-1:0] want,
  input  logic [XLEN-1:0]   va,
  input  logic [LVL_W-1:0]  lvl,
  output logic              is_leaf,
  output logic              need_wr,
  output logic [XLEN-1:0]   upd_pte,
  output logic [XLEN-1:0]   fill_pte
);
  logic [PERM_W-1:0] perm;
  logic              hit;
  logic [XLEN-1:0]   vpn;
  logic [XLEN-1:0]   low_mask;

  assign perm    = pte[PERM_LSB +: PERM_W];
  assign is_leaf = pte[PTE_V] && (|perm);
  assign hit     = |(perm & want);

  // referenced/dirty marking, only when the leaf grants something wanted
  always_comb begin
    upd_pte = pte;
    if (hit) begin
      upd_pte[PTE_REF] = 1'b1;
      if (|(want & WRITE_MASK)) upd_pte[PTE_DRT] = 1'b1;
    end
  end

  assign need_wr = (upd_pte != pte);

  // superpage: the page number bits below this level are not translated
  assign vpn = va >> PG_SHIFT;
  always_comb begin
    low_mask = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl == LVL_W'(l)) low_mask = (XLEN'(1) << (l*IDX_BITS)) - XLEN'(1);
    end
  end

  assign fill_pte = upd_pte | ((vpn & low_mask) << PG_SHIFT);
endmodule

// File: rtl/pgwalk.sv
module pgwalk import pgw_pkg::*; #(
  parameter int LEVELS    = 3,
  parameter int IDX_BITS  = 10,
  parameter int PG_SHIFT  = 12,
  parameter int PTE_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [XLEN-1:0]   va,
  input  logic [PERM_W-1:0] want,
  input  logic [XLEN-1:0]   root_base,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   pte_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rdata
);
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int VA_BITS = LEVELS*IDX_BITS + PG_SHIFT;
  localparam int HI_W    = XLEN - VA_BITS + 1;

  wstate_e           state_q, state_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [XLEN-1:0]   base_q, base_d;
  logic [XLEN-1:0]   va_q, va_d;
  logic [PERM_W-1:0] want_q, want_d;
  logic [XLEN-1:0]   wpte_q, wpte_d;
  logic [XLEN-1:0]   res_q, res_d;

  logic [HI_W-1:0] va_hi;
  logic            canon_ok;
  logic [XLEN-1:0] rd_addr;
  logic            is_leaf, need_wr;
  logic [XLEN-1:0] upd_pte, fill_pte;

  assign va_hi    = va[XLEN-1:VA_BITS-1];
  assign canon_ok = (&va_hi) || !(|va_hi);

  pgw_addr #(.LEVELS(LEVELS), .IDX_BITS(IDX_BITS), .PG_SHIFT(PG_SHIFT),
             .PTE_BYTES(PTE_BYTES)) i_addr (
    .va(va_q), .base(base_q), .lvl(lvl_q), .addr(rd_addr));

  pgw_leaf #(.LEVELS(LEVELS), .IDX_BITS(IDX_BITS), .PG_SHIFT(PG_SHIFT)) i_leaf (
    .pte(mem_rdata), .want(want_q), .va(va_q), .lvl(lvl_q),
    .is_leaf(is_leaf), .need_wr(need_wr), .upd_pte(upd_pte), .fill_pte(fill_pte));

  // next-state process
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    va_d    = va_q;
    want_d  = want_q;
    wpte_d  = wpte_q;
    res_d   = res_q;
    case (state_q)
      W_IDLE: if (start) begin
        va_d    = va;
        want_d  = want;
        base_d  = root_base;
        lvl_d   = LVL_W'(LEVELS-1);
        res_d   = '0;
        state_d = canon_ok ? W_RREQ : W_DONE;
      end
      W_RREQ: state_d = W_RWAIT;
      W_RWAIT: if (mem_rsp_valid) begin
        if (!mem_rdata[PTE_V]) begin
          res_d   = '0;
          state_d = W_DONE;
        end else if (is_leaf) begin
          wpte_d  = upd_pte;
          res_d   = fill_pte;
          state_d = need_wr ? W_WREQ : W_DONE;
        end else if (lvl_q == '0) begin
          res_d   = '0;
          state_d = W_DONE;
        end else begin
          base_d  = {mem_rdata[XLEN-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
          lvl_d   = lvl_q - 1'b1;
          state_d = W_RREQ;
        end
      end
      W_WREQ:  state_d = W_WWAIT;
      W_WWAIT: if (mem_rsp_valid) state_d = W_DONE;
      W_DONE:  state_d = W_IDLE;
      default: state_d = W_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      va_q    <= '0;
      want_q  <= '0;
      wpte_q  <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      base_q  <= base_d;
      va_q    <= va_d;
      want_q  <= want_d;
      wpte_q  <= wpte_d;
      res_q   <= res_d;
    end
  end

  assign busy      = (state_q != W_IDLE) && (state_q != W_DONE);
  assign done      = (state_q == W_DONE);
  assign pte_out   = res_q;
  assign mem_req   = (state_q == W_RREQ) || (state_q == W_WREQ);
  assign mem_we    = (state_q == W_WREQ);
  assign mem_addr  = rd_addr;
  assign mem_wdata = wpte_q;

  // R11: a request never lasts more than one cycle
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R2: done is a single-cycle pulse with busy low
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7: every write-back carries a valid, referenced entry
  p_wr_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[PTE_REF] && mem_wdata[PTE_V]));
  // R3: a non-canonical address completes at once with a zero result
  p_noncanon_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && !canon_ok) |=> (done && pte_out == '0));
  // R9: the write-back address matches the address the leaf was read from
  p_wr_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == $past(mem_addr, 2)));
endmodule

// File: tb/test_pgwalk.sv
module test_pgwalk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] va = '0;
  logic [5:0]  want = '0;
  logic [63:0] root_base = '0;
  logic        busy, done;
  logic [63:0] pte_out;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int n_rd = 0;
  int n_wr = 0;
  longint cycles = 0;
  logic [63:0] mem [logic [63:0]];

  localparam logic [63:0] ROOT = 64'h10000;
  localparam logic [63:0] T1   = 64'h20000;
  localparam logic [63:0] T0   = 64'h30000;
  localparam logic [63:0] PPN  = 64'h5A5 << 20;

  always #2.5 clk = ~clk;

  pgwalk i_pgwalk (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .want(want),
    .root_base(root_base), .busy(busy), .done(done), .pte_out(pte_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata));

  // memory responder with adjustable latency
  logic        pend;
  int          cnt;
  logic [63:0] paddr, pwd;
  logic        pwe;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; cnt <= 0; mem_rsp_valid <= 1'b0; mem_rdata <= '0;
      paddr <= '0; pwd <= '0; pwe <= 1'b0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req) begin
        pend <= 1'b1; cnt <= lat; paddr <= mem_addr; pwe <= mem_we; pwd <= mem_wdata;
      end else if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          pend <= 1'b0;
          if (pwe) begin
            mem[paddr] = pwd;
            n_wr++;
            mem_rdata <= '0;
          end else begin
            n_rd++;
            mem_rdata <= mem.exists(paddr) ? mem[paddr] : 64'h0;
          end
        end else cnt <= cnt - 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkva(input int i2, input int i1, input int i0);
    return (64'(i2) << 32) | (64'(i1) << 22) | (64'(i0) << 12) | 64'h7B4;
  endfunction

  // build a table set whose leaf sits at level lv_lvl; returns the leaf address
  function automatic logic [63:0] build(input int lv_lvl, input logic [63:0] a, input logic [63:0] leaf);
    logic [63:0] i2 = (a >> 32) & 64'h3FF;
    logic [63:0] i1 = (a >> 22) & 64'h3FF;
    logic [63:0] i0 = (a >> 12) & 64'h3FF;
    mem.delete();
    // non-leaf entries carry junk in bits 11:9 that must be cleared (R4)
    mem[ROOT + i2*8] = (lv_lvl == 2) ? leaf : (T1 | 64'hE01);
    if (lv_lvl == 2) return ROOT + i2*8;
    mem[T1 + i1*8] = (lv_lvl == 1) ? leaf : (T0 | 64'hA01);
    if (lv_lvl == 1) return T1 + i1*8;
    mem[T0 + i0*8] = leaf;
    return T0 + i0*8;
  endfunction

  // expected updated leaf per R7/R8
  function automatic logic [63:0] upd(input logic [63:0] p, input logic [5:0] w);
    logic [63:0] r = p;
    if ((p[8:3] & w) != 0) begin
      r[1] = 1'b1;
      if (w[1] || w[4]) r[2] = 1'b1;
    end
    return r;
  endfunction

  task automatic walk(input string req, input logic [63:0] a, input logic [5:0] w,
                      input logic [63:0] exp, input int exp_rd, input int exp_wr,
                      input bit chk_busy, input bit poke);
    int rd0 = n_rd;
    int wr0 = n_wr;
    int guard = 0;
    @(negedge clk);
    va = a; want = w; root_base = ROOT; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (chk_busy) chk({req, " R2 busy after start"}, 64'(busy), 64'd1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; va = 64'h0000_0400_0000_0000;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    chk({req, " R2 done seen"}, 64'(done), 64'd1);
    chk({req, " result"}, pte_out, exp);
    chk({req, " R4 read count"}, 64'(n_rd - rd0), 64'(exp_rd));
    chk({req, " R9 write count"}, 64'(n_wr - wr0), 64'(exp_wr));
    @(negedge clk);
    chk({req, " R2 done pulse ends"}, 64'(done), 64'd0);
  endtask

  initial begin
    logic [63:0] a, la, lv, u, ex;
    logic [5:0] perms [4];
    perms[0] = 6'b000001; perms[1] = 6'b000011; perms[2] = 6'b111000; perms[3] = 6'b000100;
    #1;
    chk("R1 busy in reset", 64'(busy), 64'd0);
    chk("R1 done in reset", 64'(done), 64'd0);
    chk("R1 mem_req in reset", 64'(mem_req), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 64'(busy), 64'd0);

    // sweep: leaf level x wanted bit x leaf permission set (R6 R7 R8 R9 R10)
    a = mkva(301, 291, 858);
    for (int l = 0; l < 3; l++) begin
      for (int wb = 0; wb < 6; wb++) begin
        for (int p = 0; p < 4; p++) begin
          lat = (l + wb + p) % 3;
          lv = PPN | (64'(perms[p]) << 3) | 64'h1;
          la = build(l, a, lv);
          u  = upd(lv, 6'(1 << wb));
          ex = u | (((a >> 12) & ((64'd1 << (l*10)) - 1)) << 12);
          walk("R10 R7 R8 sweep", a, 6'(1 << wb), ex, 3 - l, (u != lv) ? 1 : 0, 1'b1, 1'b0);
          chk("R9 R7 stored leaf", mem[la], u);
        end
      end
    end

    lat = 1;
    // R3: mixed high bits
    mem.delete();
    walk("R3 noncanonical", 64'h0000_0400_0000_1000, 6'b000001, 64'h0, 0, 0, 1'b0, 1'b0);
    // R3: negative canonical address, leaf at level 1
    a = ~(64'h0) << 41 | mkva(700, 13, 5);
    lv = PPN | (64'b000011 << 3) | 64'h1;
    la = build(1, a, lv);
    u = upd(lv, 6'b000010);
    walk("R3 negative canonical", a, 6'b000010, u | (((a >> 12) & 64'h3FF) << 12), 2, 1, 1'b1, 1'b0);
    chk("R8 dirty stored", mem[la], u | 64'h6);
    // R5: invalid entry at each level
    a = mkva(5, 6, 7);
    for (int k = 0; k < 3; k++) begin
      la = build(0, a, PPN | 64'h1F9);
      if (k == 0) mem[ROOT + 5*8] = 64'h1F8;
      if (k == 1) mem[T1 + 6*8] = 64'h1F8;
      if (k == 2) mem[T0 + 7*8] = PPN | 64'h1F8;
      walk("R5 invalid entry", a, 6'b000001, 64'h0, k + 1, 0, 1'b1, 1'b0);
    end
    // R6: non-leaf at the last level
    la = build(0, a, T0 | 64'h1);
    walk("R6 non-leaf at bottom", a, 6'b000001, 64'h0, 3, 0, 1'b1, 1'b0);
    // R9: already referenced and dirty -> no write
    lv = PPN | (64'b000011 << 3) | 64'h7;
    la = build(0, a, lv);
    walk("R9 unchanged no write", a, 6'b000010, lv, 3, 0, 1'b1, 1'b0);
    // R8: referenced only, supervisor write wanted -> dirty added
    lv = PPN | (64'b110000 << 3) | 64'h3;
    la = build(0, a, lv);
    walk("R8 dirty added", a, 6'b010000, lv | 64'h4, 3, 1, 1'b1, 1'b0);
    chk("R8 stored dirty", mem[la], lv | 64'h4);
    // R7: several wanted bits, one granted
    lv = PPN | (64'b000100 << 3) | 64'h1;
    la = build(2, a, lv);
    ex = (lv | 64'h2) | (((a >> 12) & ((64'd1 << 20) - 1)) << 12);
    walk("R7 multi-bit want", a, 6'b001100, ex, 1, 1, 1'b1, 1'b0);
    // R2: start while busy is ignored
    lat = 2;
    lv = PPN | (64'b000001 << 3) | 64'h1;
    la = build(0, a, lv);
    walk("R2 start while busy", a, 6'b000001, lv | 64'h2, 3, 1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R2 no second walk", 64'(busy), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule